// File: doc/BRIEF.md
# Self-Correcting Triplicated Register

This block holds one data word of parameterised width in three separate copies so that a single upset copy cannot change what the rest of the chip reads. Each copy has its own majority voter and its own next-state path. Every copy reloads from its own voter, so a copy that has flipped is overwritten with the majority value on the next clock edge.

The data word is written through a write strobe and read continuously from the voted output. Any cycle in which the three copies disagree has three effects:

- The copies repair themselves on the next edge.
- A sticky-free warning flag rises for exactly one cycle, registered.
- A saturating upset counter advances by one.

Test inputs can XOR a bit mask into one chosen copy for one cycle. This lets a bench provoke an upset and confirm that the block tolerates it.

A two-state scrub controller follows the disagreement signal:

- **ST_CLEAN**: no disagreement was seen in the previous cycle. It stays in ST_CLEAN while the copies agree. It moves to ST_SCRUB (transition *detect*) when any voter reports a mismatch.
- **ST_SCRUB**: a disagreement was seen in the previous cycle and the copies have just been reloaded. It stays in ST_SCRUB (transition *persist*) if a new mismatch is present. It returns to ST_CLEAN (transition *settle*) otherwise.

The warning flag is high exactly in ST_SCRUB.

Top module: `tmr_reg_bank`

## Requirements
- R1: While reset is low and after its release, all three copies hold RESET_VAL (default 8'hA5), so `rd_data` shows RESET_VAL; `upset_flag` is 0 and `upset_cnt` is 0.
- R2: With `wr_en` high at a rising edge, all three copies take `wr_data`, and `rd_data` shows it right after that edge.
- R3: When one copy differs from the other two in any bits, `rd_data` still shows the value that at least two copies hold, for every bit.
- R4: A copy that disagrees is rewritten from its own voter at the next edge. After one repair edge, with no new injection, the copies agree again: `upset_flag` falls one cycle later and the counter does not advance again.
- R5: `upset_flag` is high during the cycle after each cycle in which any bit of the copies disagrees, and low otherwise. A single injection gives a one-cycle pulse.
- R6: `upset_cnt` increases by exactly one for each cycle in which the copies disagree.
- R7: `upset_cnt` (16 bits by default) stops at 16'hFFFF and holds that value under further disagreement.
- R8: `cnt_clr` high at an edge sets `upset_cnt` to 0. It wins over an increment in the same cycle and does not affect `upset_flag`.
- R9: A write in a cycle where the copies disagree stores `wr_data` in all three copies. The write takes priority over the repair reload, and the disagreement is still flagged and counted.
- R10: Injection: with `inj_en` high, `inj_sel` values 0, 1 and 2 pick copy 0, 1 or 2. `inj_mask` bit i flips bit i of that copy at the edge. An `inj_sel` of 3 picks no copy and has no effect on the flag or the counter.
- R11: A mask flipping several bits, or all bits, of one copy is outvoted and repaired exactly like a single-bit flip, and counts as one upset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the three copies |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for all copies |
| wr_data | input | W | Data to store |
| cnt_clr | input | 1 | Synchronous clear of the upset counter |
| inj_en | input | 1 | Test only: enable a one-cycle flip |
| inj_sel | input | 2 | Test only: copy index (3 = none) |
| inj_mask | input | W | Test only: bits to flip in the chosen copy |
| rd_data | output | W | Majority-voted stored word |
| upset_flag | output | 1 | Registered disagreement warning |
| upset_cnt | output | CNT_W | Saturating count of disagreement cycles |

## Verification
The assertions take for granted that at most one copy is corrupted at any time. The only injection port is `inj_en`/`inj_sel`/`inj_mask`, which touches a single copy per cycle. Each edge also restores the other copies, so the stimulus can never push two copies into the minority together.

Under that assumption the voted output may change only on a write. The flag mirrors exactly the counter steps that are not masked by saturation or clear. The stimulus keeps to single-copy injections, including a long run of back-to-back flips that drives the counter to saturation.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [0:0] {
        ST_CLEAN = 1'b0,
        ST_SCRUB = 1'b1
    } scrub_state_e;

    localparam int unsigned NUM_COPIES = 3;
    localparam int unsigned SEL_W      = 2;

endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] vote,
    output logic [W-1:0] diff
);

    // bitwise two-of-three majority and per-bit minority indicator
    always_comb begin
        vote = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
        diff = (in_a ^ in_b) | (in_b ^ in_c);
    end

endmodule

// File: rtl/tmr_copy.sv
module tmr_copy #(
    parameter int unsigned     W         = 8,
    parameter logic [W-1:0]    RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         inj_hit,
    input  logic [W-1:0] inj_mask,
    input  logic [W-1:0] peer_a,
    input  logic [W-1:0] peer_b,
    output logic [W-1:0] q,
    output logic [W-1:0] vote,
    output logic         mism
);

    logic [W-1:0] diff_bits;
    logic [W-1:0] base_next;
    logic [W-1:0] flip;
    logic         load;

    // private voter for this copy: a glitch here reaches only this copy
    tmr_voter #(.W(W)) u_voter (
        .in_a (q),
        .in_b (peer_a),
        .in_c (peer_b),
        .vote (vote),
        .diff (diff_bits)
    );

    always_comb begin
        mism      = |diff_bits;
        load      = wr_en | mism;
        // write wins over repair; repair source is the voter, never raw q
        base_next = wr_en ? wr_data : vote;
        flip      = inj_hit ? inj_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            q <= (load ? base_next : q) ^ flip;
        end
    end

endmodule

// File: rtl/upset_counter.sv
module upset_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    output logic warn,
    output logic count_en
);

    scrub_state_e state_q;
    scrub_state_e state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: state_d = mismatch ? ST_SCRUB : ST_CLEAN; // detect
            ST_SCRUB: state_d = mismatch ? ST_SCRUB : ST_CLEAN; // persist / settle
            default:  state_d = ST_CLEAN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        warn     = 1'b0;
        count_en = mismatch;
        unique case (state_q)
            ST_CLEAN: warn = 1'b0;
            ST_SCRUB: warn = 1'b1;
            default:  warn = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_reg_bank.sv
module tmr_reg_bank
    import tmr_pkg::*;
#(
    parameter int unsigned  W         = 8,
    parameter int unsigned  CNT_W     = 16,
    parameter logic [W-1:0] RESET_VAL = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             cnt_clr,
    input  logic             inj_en,
    input  logic [SEL_W-1:0] inj_sel,
    input  logic [W-1:0]     inj_mask,
    output logic [W-1:0]     rd_data,
    output logic             upset_flag,
    output logic [CNT_W-1:0] upset_cnt
);

    logic [W-1:0]          copy_q [NUM_COPIES];
    logic [W-1:0]          copy_v [NUM_COPIES];
    logic [NUM_COPIES-1:0] copy_m;
    logic                  any_mism;
    logic                  cnt_inc;

    for (genvar k = 0; k < NUM_COPIES; k++) begin : g_copy
        localparam int unsigned PA = (k + 1) % NUM_COPIES;
        localparam int unsigned PB = (k + 2) % NUM_COPIES;
        logic hit;
        assign hit = inj_en && (inj_sel == SEL_W'(k));

        tmr_copy #(.W(W), .RESET_VAL(RESET_VAL)) u_copy (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_data  (wr_data),
            .inj_hit  (hit),
            .inj_mask (inj_mask),
            .peer_a   (copy_q[PA]),
            .peer_b   (copy_q[PB]),
            .q        (copy_q[k]),
            .vote     (copy_v[k]),
            .mism     (copy_m[k])
        );
    end

    assign any_mism = |copy_m;
    assign rd_data  = copy_v[0];

    scrub_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (any_mism),
        .warn     (upset_flag),
        .count_en (cnt_inc)
    );

    upset_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (upset_cnt)
    );

endmodule

// File: rtl/tmr_reg_bank_chk.sv
module tmr_reg_bank_chk #(
    parameter int unsigned W     = 8,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [W-1:0]     wr_data,
    input logic             cnt_clr,
    input logic [W-1:0]     rd_data,
    input logic             upset_flag,
    input logic [CNT_W-1:0] upset_cnt
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    // R3
    vote_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> upset_cnt == '0);

    // R7
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upset_cnt == CMAX && !cnt_clr) |=> upset_cnt == CMAX);

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (upset_cnt == $past(upset_cnt)) ||
                     (upset_cnt == $past(upset_cnt) + 1'b1));

    // R5
    flag_tracks_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && upset_cnt != CMAX) |=>
            upset_flag == (upset_cnt != $past(upset_cnt)));

endmodule

bind tmr_reg_bank tmr_reg_bank_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .cnt_clr    (cnt_clr),
    .rd_data    (rd_data),
    .upset_flag (upset_flag),
    .upset_cnt  (upset_cnt)
);

// File: tb/tmr_reg_bank_tb.sv
`timescale 1ns/1ps
module tmr_reg_bank_tb;

    localparam int unsigned W     = 8;
    localparam int unsigned CNT_W = 16;
    localparam logic [W-1:0] RVAL = 8'hA5;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [W-1:0]     wr_data = '0;
    logic             cnt_clr = 1'b0;
    logic             inj_en = 1'b0;
    logic [1:0]       inj_sel = 2'd3;
    logic [W-1:0]     inj_mask = '0;
    logic [W-1:0]     rd_data;
    logic             upset_flag;
    logic [CNT_W-1:0] upset_cnt;

    always #2.5 clk = ~clk;

    tmr_reg_bank #(.W(W), .CNT_W(CNT_W), .RESET_VAL(RVAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cnt_clr(cnt_clr), .inj_en(inj_en), .inj_sel(inj_sel),
        .inj_mask(inj_mask), .rd_data(rd_data), .upset_flag(upset_flag),
        .upset_cnt(upset_cnt)
    );

    typedef struct {
        logic [W-1:0]     d;
        logic             f;
        logic [CNT_W-1:0] c;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    // requirement-level model: voted word, counter, pending disagreement
    logic [W-1:0]     m_data = RVAL;
    logic [CNT_W-1:0] m_cnt  = '0;
    logic             m_bad  = 1'b0;

    task automatic step(input logic wr, input logic [W-1:0] wd, input logic clr,
                        input logic ie, input logic [1:0] sel,
                        input logic [W-1:0] mask, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = wr; wr_data = wd; cnt_clr = clr;
        inj_en = ie; inj_sel = sel; inj_mask = mask;
        e.f = m_bad;
        if (clr) m_cnt = '0;
        else if (m_bad && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
        if (wr) m_data = wd;
        m_bad = ie && (sel != 2'd3) && (mask != '0);
        e.d = m_data; e.c = m_cnt; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b0, 1'b0, 2'd3, '0, tag);
    endtask

    task automatic upset(input logic [1:0] sel, input logic [W-1:0] mask, input string tag);
        step(1'b0, '0, 1'b0, 1'b1, sel, mask, tag);
        idle(tag);
        idle(tag);
    endtask

    // monitor: compare each expectation one time unit after its edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (rd_data !== e.d || upset_flag !== e.f || upset_cnt !== e.c) begin
                    n_errors++;
                    $display("FAIL %s: got data=%h flag=%b cnt=%h, expected data=%h flag=%b cnt=%h",
                             e.tag, rd_data, upset_flag, upset_cnt, e.d, e.f, e.c);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        idle("R1 reset state hold");
        step(1'b1, 8'h3C, 1'b0, 1'b0, 2'd3, '0, "R2 write");
        upset(2'd1, 8'h01, "R3 R4 R5 R6 copy1 bit0");
        upset(2'd0, 8'h80, "R3 R4 R5 R6 copy0 bit7");
        upset(2'd2, 8'h10, "R10 copy2 bit4");
        upset(2'd1, 8'hFF, "R11 all bits");
        upset(2'd0, 8'h5A, "R11 multi bit");
        upset(2'd3, 8'hFF, "R10 sel3 no effect");
        step(1'b1, 8'hC3, 1'b0, 1'b0, 2'd3, '0, "R2 write second");
        step(1'b0, '0, 1'b0, 1'b1, 2'd2, 8'h0F, "R9 inject");
        step(1'b1, 8'h5A, 1'b0, 1'b0, 2'd3, '0, "R9 write during mismatch");
        idle("R9 settle");
        step(1'b0, '0, 1'b0, 1'b1, 2'd0, 8'h02, "R8 inject");
        step(1'b0, '0, 1'b1, 1'b0, 2'd3, '0, "R8 clear wins");
        idle("R8 settle");
        step(1'b0, '0, 1'b1, 1'b0, 2'd3, '0, "R7 clear");
        for (int i = 0; i < 65540; i++) begin
            step(1'b0, '0, 1'b0, 1'b1, 2'(i % 3), 8'h80, "R7 saturation run");
        end
        idle("R7 saturated");
        idle("R7 R4 settle");
        idle("R7 hold");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule